// File: doc/BRIEF.md
# Falling-Edge External Interrupt Latch

This block is a second external interrupt source for a small 8-bit microcontroller. It takes a shared port pin and passes it through a synchronizer. When the source is enabled, it records every high-to-low transition of the pin in a single interrupt latch. The CPU sees a request only while that latch is set and the CPU's global interrupt mask bit is clear. The service routine clears the latch by writing a one to a write-only bit in an 8-bit control register. Reading that bit always returns zero.

The control register sits on a simple CPU register bus that has an address, a write strobe, write data and combinational read data. Besides the enable bit and the clear bit, it holds six unrelated control fields. This block only stores those fields and reads them back. The enable bit also drives the port pin-mux select. The block reports a fixed vector address from which the CPU fetches the service routine pointer (high byte first, low byte at the next address).

The block detects edges only with the system clock. It has no asynchronous path, so it cannot wake the device from STOP.

Top module: `xirq_edge_latch`

## Requirements
- R1: After reset the control register at address 0x0C reads 0x10, the latch is clear, `irq_req_o` is 0 and `pin_sel_o` is 0.
- R2: With the enable bit (bit 0) at 1, a high-to-low transition on `pin_i` sets the latch. `irq_req_o` rises after the third rising clock edge that follows the pin change, and not before.
- R3: Only falling edges set the latch. A pin held low, or a low-to-high transition, never sets it.
- R4: `irq_req_o` is 1 exactly when the latch is set and `cpu_imask_i` is 0. Raising the mask suppresses the request without clearing the latch.
- R5: A write to 0x0C with bit 1 at 1 clears the latch. A write with bit 1 at 0 leaves the latch as it was. Bit 1 always reads as 0.
- R6: While the enable bit is 0, falling edges are ignored. Clearing the enable bit does not clear a latch that is already set.
- R7: If a clear write and a detected falling edge fall on the same clock edge, the latch ends up set.
- R8: Bits 7..2 and bit 0 of the register store the written value and read back unchanged. Writes to any other address are ignored. Reads of any other address return 0.
- R9: `pin_sel_o` equals the enable bit. `vec_addr_o` holds 0x1FF8, the address of the vector's high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Shared port pin, asynchronous |
| cpu_imask_i | input | 1 | CPU global interrupt mask bit (1 = masked) |
| reg_addr_i | input | 8 | Register bus address |
| reg_we_i | input | 1 | Register bus write strobe |
| reg_wdata_i | input | 8 | Register bus write data |
| reg_rdata_o | output | 8 | Register bus read data |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| pin_sel_o | output | 1 | Port pin-mux select, pin used as interrupt input |
| vec_addr_o | output | 16 | Address of the service vector high byte |

## Verification
The latch state is visible only through `irq_req_o` with the mask clear. A latch that is wrongly set or wrongly cleared therefore shows on the port in the same cycle as the faulty register update. An off-by-one in the synchronizer depth or in the edge comparison moves the rise of the request away from the third clock edge after the pin change. The bench samples that rise in a narrow window, so such an error shows within a cycle. A wrong clear-versus-set priority, or an edge taken while disabled, shows as a wrong request level directly after the offending cycle. A stuck or misplaced register bit shows on the next read of 0x0C.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

    localparam int unsigned REG_W  = 8;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned VEC_W  = 16;

    localparam logic [ADDR_W-1:0] CTRL_ADDR  = 8'h0C;
    localparam logic [VEC_W-1:0]  VEC_ADDR   = 16'h1FF8;
    localparam logic [REG_W-1:0]  CTRL_RESET = 8'h10;

    // bit positions the block decodes
    localparam int unsigned BIT_EN  = 0;
    localparam int unsigned BIT_CLR = 1;

    // control register layout, bit 7 first
    typedef struct packed {
        logic kb_en;     // keyboard enable (storage only)
        logic kb_ack;    // keyboard acknowledge (storage only)
        logic aux_out;   // auxiliary output select (storage only)
        logic aux_en;    // auxiliary enable (storage only)
        logic lv_rst;    // low-voltage reset enable (storage only)
        logic slow;      // slow clock mode (storage only)
        logic clr;       // write-only latch clear, never stored
        logic en;        // interrupt source enable
    } ctrl_t;

    typedef struct packed {
        logic hit;       // access addresses the control register
        logic wr;        // write to the control register
        logic clr;       // write with the clear bit set
    } bus_dec_t;

    function automatic ctrl_t ctrl_from_bus(input logic [REG_W-1:0] d);
        ctrl_t c;
        c = ctrl_t'(d);
        c.clr = 1'b0;
        return c;
    endfunction

    function automatic logic [REG_W-1:0] ctrl_to_bus(input ctrl_t c);
        logic [REG_W-1:0] d;
        d = REG_W'(c);
        d[BIT_CLR] = 1'b0;
        return d;
    endfunction

endpackage

// File: rtl/xirq_sync_edge.sv
module xirq_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic fall_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // idle level is high, so reset to 1 avoids a false edge
    always_ff @(posedge clk) begin
        if (rst) chain_q[0] <= 1'b1;
        else     chain_q[0] <= pin_i;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[i] <= 1'b1;
                else     chain_q[i] <= chain_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain_q[LAST];
    end

    assign fall_o = prev_q & ~chain_q[LAST];

endmodule

// File: rtl/xirq_ctrl_reg.sv
module xirq_ctrl_reg
    import xirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    output ctrl_t             ctrl_o,
    output logic              clr_o
);
    ctrl_t    ctrl_q;
    bus_dec_t dec;

    always_comb begin
        dec.hit = (addr_i == CTRL_ADDR);
        dec.wr  = dec.hit & we_i;
        dec.clr = dec.wr & wdata_i[BIT_CLR];
    end

    always_ff @(posedge clk) begin
        if (rst)         ctrl_q <= ctrl_t'(CTRL_RESET);
        else if (dec.wr) ctrl_q <= ctrl_from_bus(wdata_i);
    end

    always_comb begin
        if (dec.hit) rdata_o = ctrl_to_bus(ctrl_q);
        else         rdata_o = '0;
    end

    assign ctrl_o = ctrl_q;
    assign clr_o  = dec.clr;

endmodule

// File: rtl/xirq_latch.sv
module xirq_latch (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic fall_i,
    input  logic clr_i,
    output logic q_o
);
    logic q;
    logic set_w;

    assign set_w = en_i & fall_i;

    // a new edge wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (set_w) q <= 1'b1;
        else if (clr_i) q <= 1'b0;
    end

    assign q_o = q;

endmodule

// File: rtl/xirq_edge_latch.sv
module xirq_edge_latch
    import xirq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_i,
    input  logic              cpu_imask_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_req_o,
    output logic              pin_sel_o,
    output logic [VEC_W-1:0]  vec_addr_o
);
    ctrl_t ctrl_q;
    logic  clr_w;
    logic  fall_w;
    logic  latch_q;

    xirq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (pin_i),
        .fall_o (fall_w)
    );

    xirq_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (reg_addr_i),
        .we_i    (reg_we_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .ctrl_o  (ctrl_q),
        .clr_o   (clr_w)
    );

    xirq_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .en_i   (ctrl_q.en),
        .fall_i (fall_w),
        .clr_i  (clr_w),
        .q_o    (latch_q)
    );

    assign irq_req_o  = latch_q & ~cpu_imask_i;
    assign pin_sel_o  = ctrl_q.en;
    assign vec_addr_o = VEC_ADDR;

endmodule

// File: rtl/xirq_edge_latch_chk.sv
module xirq_edge_latch_chk
    import xirq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cpu_imask_i,
    input logic [ADDR_W-1:0] reg_addr_i,
    input logic              reg_we_i,
    input logic [REG_W-1:0]  reg_wdata_i,
    input logic [REG_W-1:0]  reg_rdata_o,
    input logic              irq_req_o,
    input logic              latch_q,
    input logic              fall_w,
    input logic              en_q
);
    logic clr_wr;
    assign clr_wr = reg_we_i && (reg_addr_i == CTRL_ADDR) && reg_wdata_i[BIT_CLR];

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !irq_req_o); // R1
    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst) (fall_w && en_q) |=> latch_q); // R2
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (rst) cpu_imask_i |-> !irq_req_o); // R4
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (rst) (clr_wr && !(fall_w && en_q)) |=> !latch_q); // R5
    AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst) !reg_rdata_o[BIT_CLR]); // R5
    AST_DIS_NO_SET: assert property (@(posedge clk) disable iff (rst) (!latch_q && !en_q) |=> !latch_q); // R6
    AST_HOLD_SET: assert property (@(posedge clk) disable iff (rst) (latch_q && !clr_wr) |=> latch_q); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) (clr_wr && fall_w && en_q) |=> latch_q); // R7

endmodule

bind xirq_edge_latch xirq_edge_latch_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cpu_imask_i (cpu_imask_i),
    .reg_addr_i  (reg_addr_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .irq_req_o   (irq_req_o),
    .latch_q     (latch_q),
    .fall_w      (fall_w),
    .en_q        (ctrl_q.en)
);

// File: tb/tb_xirq_edge_latch.sv
module tb_xirq_edge_latch;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_i = 1'b1;
    logic        cpu_imask_i = 1'b0;
    logic [7:0]  reg_addr_i = 8'h0C;
    logic        reg_we_i = 1'b0;
    logic [7:0]  reg_wdata_i = 8'h00;
    logic [7:0]  reg_rdata_o;
    logic        irq_req_o;
    logic        pin_sel_o;
    logic [15:0] vec_addr_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    xirq_edge_latch dut (
        .clk         (clk),
        .rst         (rst),
        .pin_i       (pin_i),
        .cpu_imask_i (cpu_imask_i),
        .reg_addr_i  (reg_addr_i),
        .reg_we_i    (reg_we_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .irq_req_o   (irq_req_o),
        .pin_sel_o   (pin_sel_o),
        .vec_addr_o  (vec_addr_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we_i = 1'b0; reg_addr_i = 8'h0C;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr_i = a;
        #1 d = reg_rdata_o;
        reg_addr_i = 8'h0C;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(8'h0C, d);
        chk("R1 reset value", {8'h0, d}, 16'h0010);
        chk("R1 irq after reset", {15'h0, irq_req_o}, 16'h0);
        chk("R1 pin select after reset", {15'h0, pin_sel_o}, 16'h0);
    endtask

    task automatic t_edge();
        wr(8'h0C, 8'h11);
        @(negedge clk) pin_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R2 not yet set after two edges", {15'h0, irq_req_o}, 16'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R2 set after third edge", {15'h0, irq_req_o}, 16'h1);
    endtask

    task automatic t_clear_and_level();
        logic [7:0] d;
        wr(8'h0C, 8'h11);
        chk("R5 write 0 to clear bit keeps latch", {15'h0, irq_req_o}, 16'h1);
        wr(8'h0C, 8'h13);
        chk("R5 write 1 clears latch", {15'h0, irq_req_o}, 16'h0);
        rd(8'h0C, d);
        chk("R5 clear bit reads 0", {8'h0, d}, 16'h0011);
        settle(5);
        chk("R3 held low does not set", {15'h0, irq_req_o}, 16'h0);
        @(negedge clk) pin_i = 1'b1;
        settle(5);
        chk("R3 rising edge does not set", {15'h0, irq_req_o}, 16'h0);
    endtask

    task automatic t_mask();
        @(negedge clk) pin_i = 1'b0;
        settle(4);
        chk("R4 set with mask clear", {15'h0, irq_req_o}, 16'h1);
        cpu_imask_i = 1'b1;
        #1 chk("R4 masked request low", {15'h0, irq_req_o}, 16'h0);
        settle(2);
        cpu_imask_i = 1'b0;
        #1 chk("R4 latch kept under mask", {15'h0, irq_req_o}, 16'h1);
        wr(8'h0C, 8'h13);
        @(negedge clk) pin_i = 1'b1;
        settle(4);
    endtask

    task automatic t_disabled();
        wr(8'h0C, 8'h10);
        chk("R9 pin select off", {15'h0, pin_sel_o}, 16'h0);
        @(negedge clk) pin_i = 1'b0;
        settle(5);
        chk("R6 edge ignored while disabled", {15'h0, irq_req_o}, 16'h0);
        wr(8'h0C, 8'h11);
        settle(3);
        chk("R6 no stale set on enable", {15'h0, irq_req_o}, 16'h0);
        @(negedge clk) pin_i = 1'b1;
        settle(4);
        @(negedge clk) pin_i = 1'b0;
        settle(4);
        chk("R6 edge taken once enabled", {15'h0, irq_req_o}, 16'h1);
        wr(8'h0C, 8'h10);
        chk("R6 latch holds after disable", {15'h0, irq_req_o}, 16'h1);
        wr(8'h0C, 8'h13);
        chk("R6 clear after re-enable", {15'h0, irq_req_o}, 16'h0);
        @(negedge clk) pin_i = 1'b1;
        settle(4);
    endtask

    task automatic t_priority();
        @(negedge clk) pin_i = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        reg_addr_i = 8'h0C; reg_wdata_i = 8'h13; reg_we_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_we_i = 1'b0;
        chk("R7 set wins over clear", {15'h0, irq_req_o}, 16'h1);
        wr(8'h0C, 8'h13);
        chk("R7 later clear works", {15'h0, irq_req_o}, 16'h0);
        @(negedge clk) pin_i = 1'b1;
        settle(4);
    endtask

    task automatic t_storage();
        logic [7:0] d;
        wr(8'h0C, 8'hFF);
        rd(8'h0C, d);
        chk("R8 all ones reads back", {8'h0, d}, 16'h00FD);
        chk("R9 pin select on", {15'h0, pin_sel_o}, 16'h1);
        wr(8'h0C, 8'hA4);
        rd(8'h0C, d);
        chk("R8 pattern reads back", {8'h0, d}, 16'h00A4);
        wr(8'h0B, 8'h5B);
        rd(8'h0C, d);
        chk("R8 other address write ignored", {8'h0, d}, 16'h00A4);
        rd(8'h0B, d);
        chk("R8 other address reads 0", {8'h0, d}, 16'h0000);
        chk("R9 vector address", vec_addr_o, 16'h1FF8);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset();
        t_edge();
        t_clear_and_level();
        t_mask();
        t_disabled();
        t_priority();
        t_storage();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule